// File: doc/BRIEF.md
# Nibble-Mode Parallel Link Endpoint

This block is one end of a crossed five-wire link between two ports that only have simple latched outputs and a handful of status inputs. A byte is moved in two halves. The low half goes out first with the fifth wire raised. The high half follows with the fifth wire lowered. The far end returns the fifth wire as an acknowledge. Each phase waits until that echo is seen, so the full transfer is a four-phase handshake.

A role input chooses between the two ends. As sender, the block takes a byte from the user side and pulses `tx_done` once the far end has acknowledged the second half. As receiver, it watches the incoming flag, collects both halves, echoes the flag and pulses `rx_valid` with the assembled byte. It drives data only as sender; as receiver it drives nothing but the flag.

The inputs are asynchronous and may be noisy. They pass through a synchronizer and then a stabilizer, which samples the five lines once every `SAMPLE_DIV` clocks. A new value is adopted only when two samples in a row agree. The wire carrying the flag reaches the far end through an inverting input, so the flag is re-inverted after the stabilizer.

Top module: `nibble_link`

## Requirements
- R1: In sender role, a byte offered with `tx_valid` while `tx_ready` is high is latched at that clock edge. From the next cycle `link_out` equals {1, byte[3:0]}: bit 4 is the flag, bits 3..0 are the data.
- R2: The sender holds the low-half pattern until the accepted returned flag reads high. It then drives {0, byte[7:4]} until the accepted returned flag reads low.
- R3: `tx_done` is a one-cycle pulse. It is raised only after the returned flag has been seen low during the high-half phase. In the same cycle `link_out` returns to 0 and `tx_ready` returns to 1.
- R4: In receiver role, the block stays idle with `link_out` = 0 until the accepted incoming flag reads high. It then stores `link_in`[3:0] as the low half and drives `link_out` = 5'b10000.
- R5: The receiver then waits for the accepted incoming flag to read low. It stores the data lines as the high half, returns `link_out` to 0 and pulses `rx_valid` for one cycle with `rx_byte` = {high half, low half}.
- R6: In receiver role, `link_out`[3:0] is always 0.
- R7: The five inputs are sampled every `SAMPLE_DIV` clocks after a `SYNC_STAGES`-flop synchronizer. A changed value takes effect only once two consecutive samples are identical. A pulse shorter than one sample interval is never accepted.
- R8: `link_in`[4] is the inverted form of the far end's flag: a raw 1 means the flag is low and a raw 0 means it is high.
- R9: A new byte is taken only while `tx_ready` is high. `tx_valid` while a transfer is in progress is ignored and does not change the byte being sent.
- R10: After reset, `link_out` = 0, `tx_done` = 0 and `rx_valid` = 0. Both roles start idle, so `tx_ready` = 1 in sender role.
- R11: `role_rx` = 1 selects receiver role and 0 selects sender role. The role not selected is held idle, so in receiver role `tx_ready` = 0 and `tx_valid` has no effect on `link_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_rx | input | 1 | 1 = receiver role, 0 = sender role |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | Offer `tx_byte` for sending |
| tx_ready | output | 1 | Sender idle and able to take a byte |
| tx_done | output | 1 | One-cycle pulse when the far end has acknowledged the byte |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is new |
| link_out | output | 5 | Lines to the far end: bits 3..0 data, bit 4 flag |
| link_in | input | 5 | Lines from the far end: bits 3..0 data, bit 4 inverted flag |

## Verification
The bound checker tests these properties on every cycle:
- the low-half pattern appears one cycle after a byte is accepted;
- the sender stays in the low-half phase until the echo arrives;
- `tx_done` fires only after the high-half phase saw the echo drop;
- the receiver's data lines stay at zero;
- the pulse outputs last a single cycle;
- the stabilized word changes only just after a sample tick.

The bench scenarios cover what needs a far end. Two instances run back to back for full byte transfers in both directions. A hand-driven far end shows the ordering of each phase and the inverted flag input. Glitches shorter than a sample interval must leave the receiver idle. Writes made while busy, or in the wrong role, must leave the delivered data untouched.

// File: rtl/nibble_link_pkg.sv
package nibble_link_pkg;

  localparam int NIB_W  = 4;
  localparam int LINE_W = NIB_W + 1;
  localparam int BYTE_W = 2 * NIB_W;

  // Quiet input word: data low, flag wire high (reads as flag low after inversion).
  localparam logic [LINE_W-1:0] LINE_IDLE = {1'b1, {NIB_W{1'b0}}};

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_LO   = 2'd1,
    TX_HI   = 2'd2
  } tx_st_t;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_ACK  = 1'b1
  } rx_st_t;

  function automatic logic [NIB_W-1:0] nib_lo(input logic [BYTE_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  function automatic logic [NIB_W-1:0] nib_hi(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:NIB_W];
  endfunction

  function automatic logic [BYTE_W-1:0] join_nibs(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [LINE_W-1:0] pack_line(input logic flag,
                                                  input logic [NIB_W-1:0] nib);
    return {flag, nib};
  endfunction

  // The flag wire reaches this end through an inverting input.
  function automatic logic line_flag(input logic raw);
    return ~raw;
  endfunction

endpackage

// File: rtl/nl_sync.sv
module nl_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/nl_stabilizer.sv
module nl_stabilizer #(
  parameter int W = 5,
  parameter int SAMPLE_DIV = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         samp_tick
);

  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  prev_q;
  logic [W-1:0]  acc_q;

  assign samp_tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (samp_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Two consecutive matching samples are needed before a value is adopted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      acc_q  <= RST_VAL;
    end else if (samp_tick) begin
      prev_q <= din;
      if (din == prev_q) acc_q <= din;
    end
  end

  assign dout = acc_q;

endmodule

// File: rtl/nl_sender.sv
module nl_sender
  import nibble_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  input  logic              flag_in,
  output logic [LINE_W-1:0] line_out,
  output logic              in_lo,
  output logic              in_hi
);

  tx_st_t            st_q;
  logic [BYTE_W-1:0] byte_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        st_q <= TX_IDLE;
      end else begin
        case (st_q)
          TX_IDLE: if (tx_valid) begin
            byte_q <= tx_byte;
            st_q   <= TX_LO;
          end
          TX_LO: if (flag_in) st_q <= TX_HI;
          TX_HI: if (!flag_in) begin
            st_q   <= TX_IDLE;
            done_q <= 1'b1;
          end
          default: st_q <= TX_IDLE;
        endcase
      end
    end
  end

  assign in_lo    = (st_q == TX_LO);
  assign in_hi    = (st_q == TX_HI);
  assign tx_ready = en && (st_q == TX_IDLE);
  assign tx_done  = done_q;

  always_comb begin
    case (st_q)
      TX_LO:   line_out = pack_line(1'b1, nib_lo(byte_q));
      TX_HI:   line_out = pack_line(1'b0, nib_hi(byte_q));
      default: line_out = '0;
    endcase
  end

endmodule

// File: rtl/nl_receiver.sv
module nl_receiver
  import nibble_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              flag_in,
  input  logic [NIB_W-1:0]  in_nib,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [LINE_W-1:0] line_out
);

  rx_st_t            st_q;
  logic [NIB_W-1:0]  lo_q;
  logic [BYTE_W-1:0] byte_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      lo_q    <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: if (flag_in) begin
            lo_q <= in_nib;
            st_q <= RX_ACK;
          end
          RX_ACK: if (!flag_in) begin
            byte_q  <= join_nibs(in_nib, lo_q);
            valid_q <= 1'b1;
            st_q    <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;
  // Only the flag is ever driven; data lines stay low.
  assign line_out = (st_q == RX_ACK) ? pack_line(1'b1, '0) : '0;

endmodule

// File: rtl/nibble_link.sv
module nibble_link
  import nibble_link_pkg::*;
#(
  parameter int SAMPLE_DIV  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_rx,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [LINE_W-1:0] link_out,
  input  logic [LINE_W-1:0] link_in
);

  logic [LINE_W-1:0] sync_word;
  logic [LINE_W-1:0] stab_word;
  logic              samp_tick;
  logic              flag_in;
  logic [NIB_W-1:0]  in_nib;
  logic [LINE_W-1:0] tx_line;
  logic [LINE_W-1:0] rx_line;
  logic              tx_in_lo;
  logic              tx_in_hi;

  nl_sync #(
    .W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(link_in), .q(sync_word)
  );

  nl_stabilizer #(
    .W(LINE_W), .SAMPLE_DIV(SAMPLE_DIV), .RST_VAL(LINE_IDLE)
  ) u_stab (
    .clk(clk), .rst_n(rst_n), .din(sync_word), .dout(stab_word),
    .samp_tick(samp_tick)
  );

  assign flag_in = line_flag(stab_word[LINE_W-1]);
  assign in_nib  = stab_word[NIB_W-1:0];

  nl_sender u_tx (
    .clk(clk), .rst_n(rst_n), .en(!role_rx),
    .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done),
    .flag_in(flag_in), .line_out(tx_line),
    .in_lo(tx_in_lo), .in_hi(tx_in_hi)
  );

  nl_receiver u_rx (
    .clk(clk), .rst_n(rst_n), .en(role_rx),
    .flag_in(flag_in), .in_nib(in_nib),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .line_out(rx_line)
  );

  assign link_out = role_rx ? rx_line : tx_line;

endmodule

// File: rtl/nl_checker.sv
module nl_checker
  import nibble_link_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              role_rx,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_done,
  input logic              rx_valid,
  input logic [LINE_W-1:0] link_out,
  input logic              flag_in,
  input logic              tx_in_lo,
  input logic              tx_in_hi,
  input logic              samp_tick,
  input logic [LINE_W-1:0] stab_word
);

  p_lo_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (link_out == {1'b1, $past(tx_byte[NIB_W-1:0])}));

  p_hold_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_rx && tx_in_lo && !flag_in) |=> (tx_in_lo || role_rx));

  p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(tx_in_hi && !flag_in));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    role_rx |-> (link_out[NIB_W-1:0] == '0));

  p_stab_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stab_word) |-> $past(samp_tick));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!role_rx && link_out == '0));

endmodule

bind nibble_link nl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .role_rx(role_rx), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_done(tx_done),
  .rx_valid(rx_valid), .link_out(link_out), .flag_in(flag_in),
  .tx_in_lo(tx_in_lo), .tx_in_hi(tx_in_hi), .samp_tick(samp_tick),
  .stab_word(stab_word)
);

// File: tb/tb_nibble_link.sv
`timescale 1ns/1ps
module tb_nibble_link;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       dut_role, dut_txv, dut_ready, dut_done, dut_rxv;
  logic [7:0] dut_txb, dut_rxb;
  logic [4:0] dut_out, dut_in;
  logic       peer_txv, peer_ready, peer_done, peer_rxv;
  logic [7:0] peer_txb, peer_rxb;
  logic [4:0] peer_out, peer_in;
  logic       loop;
  logic [4:0] man_in;

  // Crossed cable: flag wire arrives inverted (R8).
  assign dut_in  = loop ? {~peer_out[4], peer_out[3:0]} : man_in;
  assign peer_in = {~dut_out[4], dut_out[3:0]};

  nibble_link dut (
    .clk(clk), .rst_n(rst_n), .role_rx(dut_role),
    .tx_byte(dut_txb), .tx_valid(dut_txv), .tx_ready(dut_ready),
    .tx_done(dut_done), .rx_byte(dut_rxb), .rx_valid(dut_rxv),
    .link_out(dut_out), .link_in(dut_in)
  );

  nibble_link peer (
    .clk(clk), .rst_n(rst_n), .role_rx(~dut_role),
    .tx_byte(peer_txb), .tx_valid(peer_txv), .tx_ready(peer_ready),
    .tx_done(peer_done), .rx_byte(peer_rxb), .rx_valid(peer_rxv),
    .link_out(peer_out), .link_in(peer_in)
  );

  int checks = 0;
  int errors = 0;
  int dut_done_n = 0, peer_done_n = 0, dut_rx_n = 0, peer_rx_n = 0;
  int r6_bad = 0;
  logic [7:0] dut_rx_last = '0, peer_rx_last = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dut_done)  dut_done_n++;
      if (peer_done) peer_done_n++;
      if (dut_rxv)  begin dut_rx_n++;  dut_rx_last  = dut_rxb;  end
      if (peer_rxv) begin peer_rx_n++; peer_rx_last = peer_rxb; end
      if (dut_role && dut_out[3:0] != 4'h0) r6_bad++;
      if (!dut_role && peer_out[3:0] != 4'h0) r6_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dut_send(input logic [7:0] b);
    dut_txb = b; dut_txv = 1'b1;
    @(negedge clk);
    dut_txv = 1'b0;
  endtask

  task automatic t_reset;
    chk(dut_out == 5'h00, "R10 link_out after reset", dut_out, 0);
    chk(dut_ready == 1'b1, "R10 tx_ready after reset", dut_ready, 1);
    chk(dut_done == 1'b0 && dut_rxv == 1'b0, "R10 pulses low after reset",
        {dut_done, dut_rxv}, 0);
  endtask

  task automatic t_loop_tx(input logic [7:0] b);
    int d0 = dut_done_n;
    int r0 = peer_rx_n;
    dut_send(b);
    chk(dut_out == {1'b1, b[3:0]}, "R1 low half with flag high", dut_out, {1'b1, b[3:0]});
    for (int i = 0; i < 2000 && dut_done_n == d0; i++) @(negedge clk);
    chk(dut_done_n == d0 + 1, "R3 tx_done seen", dut_done_n - d0, 1);
    chk(peer_rx_n == r0 + 1, "R3 receiver acked before done", peer_rx_n - r0, 1);
    chk(peer_rx_last == b, "R5 byte assembled at far end", peer_rx_last, b);
    chk(dut_ready == 1'b1 && dut_out == 5'h00, "R3 idle after done", dut_out, 0);
    idle(20);
  endtask

  task automatic t_loop_rx(input logic [7:0] b);
    int r0 = dut_rx_n;
    dut_role = 1'b1;
    idle(30);
    peer_txb = b; peer_txv = 1'b1;
    @(negedge clk);
    peer_txv = 1'b0;
    for (int i = 0; i < 2000 && dut_rx_n == r0; i++) @(negedge clk);
    chk(dut_rx_n == r0 + 1, "R5 rx_valid pulse count", dut_rx_n - r0, 1);
    chk(dut_rx_last == b, "R5 received byte", dut_rx_last, b);
    chk(dut_out == 5'h00, "R5 flag dropped after byte", dut_out, 0);
    idle(30);
    dut_role = 1'b0;
    idle(30);
  endtask

  task automatic t_manual_rx;
    int r0 = dut_rx_n;
    loop = 1'b0; man_in = 5'h10; dut_role = 1'b1;
    idle(30);
    chk(dut_out == 5'h00, "R4 idle until flag high", dut_out, 0);
    man_in = 5'h06;              // raw line4 low = flag high, low half 6
    idle(30);
    chk(dut_out == 5'h10, "R4 flag raised after low half", dut_out, 5'h10);
    chk(dut_rx_n == r0, "R4 no byte yet", dut_rx_n - r0, 0);
    man_in = 5'h19;              // flag low, high half 9
    idle(30);
    chk(dut_rx_n == r0 + 1 && dut_rx_last == 8'h96, "R5 assembled 0x96", dut_rx_last, 8'h96);
    chk(dut_out == 5'h00, "R5 flag lowered", dut_out, 0);
    man_in = 5'h10;
    idle(30);
  endtask

  task automatic t_glitch;
    int r0 = dut_rx_n;
    loop = 1'b0; man_in = 5'h10; dut_role = 1'b1;
    idle(30);
    man_in = 5'h00; @(negedge clk); man_in = 5'h10;
    idle(30);
    chk(dut_out == 5'h00, "R7 one-cycle glitch ignored", dut_out, 0);
    man_in = 5'h03; idle(2); man_in = 5'h10;
    idle(30);
    chk(dut_out == 5'h00, "R7 two-cycle glitch ignored", dut_out, 0);
    chk(dut_rx_n == r0, "R7 no byte from glitches", dut_rx_n - r0, 0);
    man_in = 5'h05;
    idle(30);
    chk(dut_out == 5'h10, "R7 steady value accepted", dut_out, 5'h10);
    man_in = 5'h1A;
    idle(30);
    chk(dut_rx_last == 8'hA5 && dut_rx_n == r0 + 1, "R7 byte after steady input",
        dut_rx_last, 8'hA5);
    man_in = 5'h10;
    idle(30);
  endtask

  task automatic t_manual_tx;
    int d0;
    loop = 1'b0; man_in = 5'h10; dut_role = 1'b0;
    idle(30);
    d0 = dut_done_n;
    dut_send(8'hC3);
    chk(dut_out == 5'h13, "R1 low half 3 with flag", dut_out, 5'h13);
    idle(40);
    chk(dut_out == 5'h13, "R8 raw line4 high reads as flag low", dut_out, 5'h13);
    chk(dut_done_n == d0, "R2 no done before echo", dut_done_n - d0, 0);
    man_in = 5'h00;              // raw line4 low = echo high
    idle(30);
    chk(dut_out == 5'h0C, "R2 high half with flag low", dut_out, 5'h0C);
    chk(dut_done_n == d0, "R3 no done before second ack", dut_done_n - d0, 0);
    man_in = 5'h10;
    idle(30);
    chk(dut_done_n == d0 + 1, "R3 done after second ack", dut_done_n - d0, 1);
    chk(dut_out == 5'h00 && dut_ready, "R3 idle after done", dut_out, 0);
    loop = 1'b1;
    idle(60);
  endtask

  task automatic t_busy_ignore;
    int r0 = peer_rx_n;
    int d0 = dut_done_n;
    dut_send(8'h3C);
    idle(2);
    chk(dut_ready == 1'b0, "R9 not ready while busy", dut_ready, 0);
    dut_send(8'hFF);
    chk(dut_out == 5'h1C, "R9 busy write leaves pattern", dut_out, 5'h1C);
    for (int i = 0; i < 2000 && dut_done_n == d0; i++) @(negedge clk);
    idle(150);
    chk(peer_rx_n == r0 + 1, "R9 exactly one byte delivered", peer_rx_n - r0, 1);
    chk(peer_rx_last == 8'h3C, "R9 original byte kept", peer_rx_last, 8'h3C);
    chk(dut_done_n == d0 + 1, "R9 exactly one done", dut_done_n - d0, 1);
  endtask

  task automatic t_role;
    int r0 = peer_rx_n;
    dut_role = 1'b1;
    idle(30);
    chk(dut_ready == 1'b0, "R11 tx_ready low in receiver role", dut_ready, 0);
    dut_send(8'h77);
    idle(60);
    chk(dut_out == 5'h00, "R11 tx_valid no effect in receiver role", dut_out, 0);
    chk(peer_rx_n == r0, "R11 nothing sent", peer_rx_n - r0, 0);
    dut_role = 1'b0;
    idle(30);
  endtask

  initial begin
    dut_role = 1'b0; dut_txv = 1'b0; dut_txb = '0;
    peer_txv = 1'b0; peer_txb = '0;
    loop = 1'b1; man_in = 5'h10;
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    idle(20);
    t_loop_tx(8'hA5);
    t_loop_tx(8'h00);
    t_loop_tx(8'hFF);
    t_loop_tx(8'h5A);
    t_loop_rx(8'h3C);
    t_loop_rx(8'hE1);
    t_manual_tx();
    t_manual_rx();
    t_glitch();
    loop = 1'b1; dut_role = 1'b0;
    idle(60);
    t_busy_ignore();
    t_role();
    chk(r6_bad == 0, "R6 receiver data lines zero", r6_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule